// File: doc/BRIEF.md
# Four-Bit Dual-Mode ALU Slice

This block is a purely combinational ALU slice. It takes two operands, a four-bit function code, a mode bit and an active-high carry input. In logic mode it applies one of sixteen bitwise two-input functions to the operands. In arithmetic mode it forms one of sixteen sums of operand-derived terms, and the carry input is added to that sum. Counting the carry, this gives thirty-two arithmetic results.

Subtraction uses the ones-complement form. With the carry clear, the result is the minuend minus the subtrahend minus one. With the carry set, the result is the exact two's-complement difference. Wider datapaths can chain slices by feeding one slice's carry output into the next slice's carry input, or by choosing between precomputed upper results. The operand width is a parameter with a default of four bits.

Top module: `alu_slice`

## Requirements
- R1: When logic_mode is 1, each result bit is a function of the matching opnd_a bit (a) and opnd_b bit (b), selected by func_sel as follows: 0:~a, 1:~(a|b), 2:~a&b, 3:0, 4:~(a&b), 5:~b, 6:a^b, 7:a&~b, 8:~a|b, 9:~(a^b), 10:b, 11:a&b, 12:1, 13:a|~b, 14:a|b, 15:a.
- R2: When logic_mode is 1, carry_in has no effect on result or carry_out.
- R3: When logic_mode is 1, carry_out is 0.
- R4: When logic_mode is 0, result is the low WIDTH bits of P + Q + carry_in. P is chosen by func_sel[1:0] (0:A, 1:A|B, 2:A|~B, 3:all ones). Q is chosen by func_sel[3:2] (0:zero, 1:A&~B, 2:A&B, 3:A).
- R5: When logic_mode is 0, carry_out is bit WIDTH of the (WIDTH+1)-bit sum P + Q + carry_in.
- R6: With logic_mode 0 and func_sel 6, the slice subtracts. It gives A-B-1 when carry_in is 0 and A-B when carry_in is 1, both modulo 2^WIDTH. carry_out is 1 exactly when no borrow occurs.
- R7: With logic_mode 0, func_sel 0 and carry_in 1, the slice increments A. An all-ones A wraps to zero with carry_out 1.
- R8: With logic_mode 0, func_sel 15 and carry_in 0, the slice decrements A. A zero A gives all ones with carry_out 0.
- R9: With logic_mode 0, func_sel 12 and carry_in 0, the slice doubles A. carry_out equals the top bit of A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| func_sel | input | 4 | Function code |
| logic_mode | input | 1 | 1 selects bitwise logic, 0 selects arithmetic |
| carry_in | input | 1 | Active-high carry added in arithmetic mode |
| result | output | WIDTH | Function result |
| carry_out | output | 1 | Carry out of the arithmetic sum; 0 in logic mode |

## Verification
The bench builds the slice with the default WIDTH of 4. At that width the whole input space has only 2^14 points, so every operand pair, function code, mode and carry value is compared against a model written from the requirements. This covers every wrap, borrow and carry boundary of every function, not only a sampled subset. A vector table and directed cases also pin down the named arithmetic idioms and the cases where the carry must be ignored.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  localparam int unsigned SEL_W = 4;

  typedef enum logic [1:0] {
    P_A       = 2'd0,
    P_A_OR_B  = 2'd1,
    P_A_OR_NB = 2'd2,
    P_ONES    = 2'd3
  } p_term_e;

  typedef enum logic [1:0] {
    Q_ZERO     = 2'd0,
    Q_A_AND_NB = 2'd1,
    Q_A_AND_B  = 2'd2,
    Q_A        = 2'd3
  } q_term_e;

  function automatic logic logic_bit(input logic [SEL_W-1:0] sel,
                                     input logic a, input logic b);
    logic r;
    case (sel)
      4'd0:    r = ~a;
      4'd1:    r = ~(a | b);
      4'd2:    r = ~a & b;
      4'd3:    r = 1'b0;
      4'd4:    r = ~(a & b);
      4'd5:    r = ~b;
      4'd6:    r = a ^ b;
      4'd7:    r = a & ~b;
      4'd8:    r = ~a | b;
      4'd9:    r = ~(a ^ b);
      4'd10:   r = b;
      4'd11:   r = a & b;
      4'd12:   r = 1'b1;
      4'd13:   r = a | ~b;
      4'd14:   r = a | b;
      default: r = a;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_slice_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [WIDTH-1:0] f_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_comb f_o[g] = logic_bit(sel_i, a_i[g], b_i[g]);
  end

endmodule

// File: rtl/alu_arith_terms.sv
module alu_arith_terms
  import alu_slice_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [WIDTH-1:0] p_o,
  output logic [WIDTH-1:0] q_o
);

  p_term_e p_sel;
  q_term_e q_sel;

  always_comb begin
    p_sel = p_term_e'(sel_i[1:0]);
    q_sel = q_term_e'(sel_i[3:2]);
  end

  always_comb begin
    case (p_sel)
      P_A:       p_o = a_i;
      P_A_OR_B:  p_o = a_i | b_i;
      P_A_OR_NB: p_o = a_i | ~b_i;
      default:   p_o = '1;
    endcase
  end

  always_comb begin
    case (q_sel)
      Q_ZERO:     q_o = '0;
      Q_A_AND_NB: q_o = a_i & ~b_i;
      Q_A_AND_B:  q_o = a_i & b_i;
      default:    q_o = a_i;
    endcase
  end

endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] s_o,
  output logic             c_o
);

  logic [WIDTH:0] chain;

  always_comb chain[0] = c_i;

  for (genvar g = 0; g < WIDTH; g++) begin : g_fa
    logic prop;
    logic gen;
    always_comb begin
      prop        = x_i[g] ^ y_i[g];
      gen         = x_i[g] & y_i[g];
      s_o[g]      = prop ^ chain[g];
      chain[g+1]  = gen | (prop & chain[g]);
    end
  end

  always_comb c_o = chain[WIDTH];

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [SEL_W-1:0] func_sel,
  input  logic             logic_mode,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);

  logic [WIDTH-1:0] logic_f;
  logic [WIDTH-1:0] term_p;
  logic [WIDTH-1:0] term_q;
  logic [WIDTH-1:0] sum_f;
  logic             sum_c;

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .sel_i (func_sel),
    .f_o   (logic_f)
  );

  alu_arith_terms #(.WIDTH(WIDTH)) u_terms (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .sel_i (func_sel),
    .p_o   (term_p),
    .q_o   (term_q)
  );

  alu_ripple_adder #(.WIDTH(WIDTH)) u_add (
    .x_i (term_p),
    .y_i (term_q),
    .c_i (carry_in),
    .s_o (sum_f),
    .c_o (sum_c)
  );

  always_comb begin
    if (logic_mode) begin
      result    = logic_f;
      carry_out = 1'b0;
    end else begin
      result    = sum_f;
      carry_out = sum_c;
    end
  end

endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk
  import alu_slice_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [SEL_W-1:0] func_sel,
  input logic             logic_mode,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);

  logic [WIDTH:0] ext_a;
  logic [WIDTH:0] ext_b;
  logic           known;

  always_comb begin
    ext_a = {1'b0, opnd_a};
    ext_b = {1'b0, opnd_b};
    known = !$isunknown({opnd_a, opnd_b, func_sel, logic_mode, carry_in});
  end

  always_comb begin
    if (known) begin
      assert_logic_cout_zero_R3: assert (!logic_mode || carry_out == 1'b0)
        else $error("R3: carry_out set in logic mode");
      assert_add_sum_R5: assert (logic_mode || func_sel != 4'd9 ||
                                 {carry_out, result} == ext_a + ext_b + {{WIDTH{1'b0}}, carry_in})
        else $error("R5: A+B+cin mismatch");
      assert_sub_borrow_R6: assert (logic_mode || func_sel != 4'd6 || !carry_in ||
                                    (carry_out == (opnd_a >= opnd_b) &&
                                     result == WIDTH'(opnd_a - opnd_b)))
        else $error("R6: subtract mismatch");
      assert_double_msb_R9: assert (logic_mode || func_sel != 4'd12 || carry_in ||
                                    (carry_out == opnd_a[WIDTH-1] &&
                                     result == {opnd_a[WIDTH-2:0], 1'b0}))
        else $error("R9: doubling mismatch");
      assert_pass_a_R1: assert (!logic_mode || func_sel != 4'd15 || result == opnd_a)
        else $error("R1: pass-through of A mismatch");
    end
  end

endmodule

bind alu_slice alu_slice_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/alu_slice_tb_top.sv
module alu_slice_tb_top;

  localparam int W = 4;

  logic         clk;
  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic [3:0]   func_sel;
  logic         logic_mode;
  logic         carry_in;
  logic [W-1:0] result;
  logic         carry_out;

  int n_run;
  int n_fail;
  bit done;

  alu_slice #(.WIDTH(W)) dut_i (
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .func_sel   (func_sel),
    .logic_mode (logic_mode),
    .carry_in   (carry_in),
    .result     (result),
    .carry_out  (carry_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: a, b, sel, mode, cin, exp_f, exp_c  (19 bits)
  localparam int NV = 13;
  localparam logic [18:0] VEC [NV] = '{
    {4'h9, 4'h3, 4'd9,  1'b0, 1'b0, 4'hC, 1'b0},  // R4 add
    {4'h9, 4'h8, 4'd9,  1'b0, 1'b1, 4'h2, 1'b1},  // R5 add with carry out
    {4'h5, 4'h3, 4'd6,  1'b0, 1'b0, 4'h1, 1'b1},  // R6 A-B-1
    {4'h5, 4'h3, 4'd6,  1'b0, 1'b1, 4'h2, 1'b1},  // R6 A-B
    {4'h3, 4'h5, 4'd6,  1'b0, 1'b1, 4'hE, 1'b0},  // R6 borrow
    {4'hF, 4'h0, 4'd0,  1'b0, 1'b1, 4'h0, 1'b1},  // R7 increment wrap
    {4'h0, 4'h7, 4'd15, 1'b0, 1'b0, 4'hF, 1'b0},  // R8 decrement of zero
    {4'h6, 4'h0, 4'd15, 1'b0, 1'b0, 4'h5, 1'b1},  // R8 decrement
    {4'h9, 4'h0, 4'd12, 1'b0, 1'b0, 4'h2, 1'b1},  // R9 double
    {4'hC, 4'hA, 4'd6,  1'b1, 1'b0, 4'h6, 1'b0},  // R1 xor
    {4'hC, 4'hA, 4'd6,  1'b1, 1'b1, 4'h6, 1'b0},  // R2 cin ignored
    {4'hC, 4'hA, 4'd11, 1'b1, 1'b0, 4'h8, 1'b0},  // R1 and
    {4'hC, 4'hA, 4'd1,  1'b1, 1'b1, 4'h1, 1'b0}   // R3 nor, cout zero
  };

  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic [3:0] s, input logic m, input logic c);
    logic [W-1:0] f;
    logic [W:0]   base;
    logic [W:0]   ea;
    logic [W:0]   ones;
    ea   = {1'b0, a};
    ones = {1'b0, {W{1'b1}}};
    if (m) begin
      case (s)
        4'd0: f = ~a;          4'd1: f = ~(a | b);
        4'd2: f = ~a & b;      4'd3: f = '0;
        4'd4: f = ~(a & b);    4'd5: f = ~b;
        4'd6: f = a ^ b;       4'd7: f = a & ~b;
        4'd8: f = ~a | b;      4'd9: f = ~(a ^ b);
        4'd10: f = b;          4'd11: f = a & b;
        4'd12: f = '1;         4'd13: f = a | ~b;
        4'd14: f = a | b;      default: f = a;
      endcase
      return {1'b0, f};
    end
    case (s)
      4'd0:  base = ea;
      4'd1:  base = {1'b0, a | b};
      4'd2:  base = {1'b0, a | ~b};
      4'd3:  base = ones;
      4'd4:  base = ea + {1'b0, a & ~b};
      4'd5:  base = {1'b0, a | b} + {1'b0, a & ~b};
      4'd6:  base = ea + {1'b0, ~b};
      4'd7:  base = {1'b0, a & ~b} + ones;
      4'd8:  base = ea + {1'b0, a & b};
      4'd9:  base = ea + {1'b0, b};
      4'd10: base = {1'b0, a | ~b} + {1'b0, a & b};
      4'd11: base = {1'b0, a & b} + ones;
      4'd12: base = ea + ea;
      4'd13: base = {1'b0, a | b} + ea;
      4'd14: base = {1'b0, a | ~b} + ea;
      default: base = ea + ones;
    endcase
    return base + {{W{1'b0}}, c};
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [3:0] s, input logic m, input logic c);
    @(posedge clk);
    #1;
    opnd_a = a; opnd_b = b; func_sel = s; logic_mode = m; carry_in = c;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] ef, input logic ec);
    n_run++;
    if (result !== ef || carry_out !== ec) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h s=%0d m=%b cin=%b got f=%h c=%b exp f=%h c=%b",
               req, opnd_a, opnd_b, func_sel, logic_mode, carry_in,
               result, carry_out, ef, ec);
    end
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    opnd_a = '0; opnd_b = '0; func_sel = '0; logic_mode = 1'b1; carry_in = 1'b0;

    // initial state: logic mode, sel 0 -> ~A = all ones (R1)
    @(negedge clk);
    check("R1 initial", 4'hF, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][18:15], VEC[i][14:11], VEC[i][10:7], VEC[i][6], VEC[i][5]);
      check(VEC[i][6] ? "R1/R2/R3 table" : "R4-table", VEC[i][4:1], VEC[i][0]);
    end

    // exhaustive sweep against the model: R1 R2 R3 R4 R5
    for (int v = 0; v < (1 << 14); v++) begin
      logic [W:0] e;
      apply(v[3:0], v[7:4], v[11:8], v[12], v[13]);
      e = model(v[3:0], v[7:4], v[11:8], v[12], v[13]);
      check(v[12] ? "R1_R2_R3 sweep" : "R4_R5 sweep", e[W-1:0], e[W]);
    end

    // R2: toggle carry with logic operands fixed, output must not move
    apply(4'h5, 4'h9, 4'd14, 1'b1, 1'b0);
    check("R2 cin=0", 4'hD, 1'b0);
    apply(4'h5, 4'h9, 4'd14, 1'b1, 1'b1);
    check("R2 cin=1", 4'hD, 1'b0);

    // corners: R6 equal operands, R7 zero increment, R9 msb clear
    apply(4'h7, 4'h7, 4'd6, 1'b0, 1'b1);
    check("R6 equal", 4'h0, 1'b1);
    apply(4'h7, 4'h7, 4'd6, 1'b0, 1'b0);
    check("R6 equal minus one", 4'hF, 1'b0);
    apply(4'h0, 4'h0, 4'd0, 1'b0, 1'b1);
    check("R7 zero+1", 4'h1, 1'b0);
    apply(4'h7, 4'h0, 4'd12, 1'b0, 1'b0);
    check("R9 msb clear", 4'hE, 1'b0);
    apply(4'h1, 4'h0, 4'd15, 1'b0, 1'b0);
    check("R8 one minus one", 4'h0, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule